// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block runs the entry sequence of an 8-bit processor core when the core is reset or when an interrupt is taken. It keeps a mask of pending requests: one bit per level-type IRQ source, one bit for a one-shot IRQ request and one bit for the NMI. At each instruction boundary that the core signals, it decides whether to enter a service routine. To enter, it pushes the return address and a copy of the status byte onto the stack page through a byte-wide memory port. It then reads a two-byte vector and hands the core a new program counter, status byte and stack pointer.

The core keeps ownership of its registers. It presents its program counter, status, stack pointer and the status sampled before the instruction that just completed. Every entry sequence ends with a one-cycle `done` pulse, and the results are taken on that pulse. While `busy` is high the core stays stalled. After reset the block fetches the reset vector by itself and signals the core to leave the jammed state.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `done` is 0, `mem_we` is 0 and `pend_mask` is 0. After release the block reads 0xFFFC (low byte) and 0xFFFD (high byte) without any write. It then pulses `done` together with `jam_clr`, with `pc_out` equal to that vector, `status_out` equal to 0x04 and `sp_out` equal to `sp_in`. Reset acts even while `jammed` is 1.
- R2: An entry starts only on a clock edge where `boundary` is 1 and the block is idle. A `boundary` strobe during a sequence has no effect, and a request stays pending until a later strobe.
- R3: While `jammed` is 1, a boundary starts no entry for any request.
- R4: When the NMI bit is pending, the NMI is entered even if IRQ bits are also pending. Its vector is read from 0xFFFA (low byte) and 0xFFFB (high byte).
- R5: An IRQ request is any pending source bit or the one-shot bit. It is entered only when bit 2 (I) of `status_prev` is 0, and its vector is read from 0xFFFE (low byte) and 0xFFFF (high byte). The NMI ignores `status_prev`.
- R6: An entry makes exactly three writes, in this order: PC[15:8] to 0x0100+S, then PC[7:0] to 0x0100+S-1, then status to 0x0100+S-2. Here S is `sp_in` at the start, the low byte wraps modulo 256, and `sp_out` is S-3.
- R7: The pushed status byte is `status_in` with bit 4 (B) cleared and bit 5 (U) set.
- R8: `status_out` is `status_in` with bit 4 cleared. After an IRQ entry bit 2 is also set; after an NMI entry bit 2 is left as it was.
- R9: `busy` is high for exactly 7 cycles of an NMI or IRQ entry. On the next cycle `done` pulses for one cycle, with `pc_out`, `status_out` and `sp_out` valid. Those outputs then hold until the next `done`. `jam_clr` is 0 on these entries.
- R10: `pend_mask` bits [N_SRC-1:0] are the sources, bit N_SRC is the one-shot request and bit N_SRC+1 is the NMI. A source bit is set by `src_set` and cleared by `src_clr`, and set wins when both arrive together. Starting any entry clears the one-shot and NMI bits and leaves the source bits as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also launches the reset vector fetch |
| boundary | input | 1 | Core is at an instruction boundary |
| jammed | input | 1 | Core is halted; no interrupt may be entered |
| status_prev | input | 8 | Status byte as it was before the last instruction (bit 2 = I) |
| status_in | input | 8 | Current status byte, pushed and used to form the new status |
| pc_in | input | 16 | Return address to push |
| sp_in | input | 8 | Current stack pointer |
| src_set | input | N_SRC | Per-source IRQ set strobes |
| src_clr | input | N_SRC | Per-source IRQ clear strobes |
| nmi_req | input | 1 | NMI request strobe |
| oneshot_req | input | 1 | One-shot IRQ request strobe |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: new PC, status and SP are valid |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New status byte |
| sp_out | output | 8 | New stack pointer |
| jam_clr | output | 1 | Pulses with `done` after reset to release the jammed core |
| pend_mask | output | N_SRC+2 | Pending request mask |

## Verification
The assertions assume that memory answers a read in the same cycle as the address. They also assume that `boundary` arrives from a core that obeys `busy`, so a strobe during a sequence is a stray event the block must ignore. `pc_in`, `status_in` and `sp_in` may change freely after the start edge. The stimulus drives every input on the falling edge and generates each request as a one-cycle strobe. It leaves at least one idle cycle between entries, and after each vector it drains any request left behind by a masked or jammed case. It deliberately raises `boundary` once during a sequence to show that the strobe is ignored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT1,
    ST_INT2,
    ST_PSH_H,
    ST_PSH_L,
    ST_PSH_P,
    ST_VEC_L,
    ST_VEC_H
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_RST,
    KIND_NMI,
    KIND_IRQ
  } entry_kind_e;

  localparam logic [15:0] VEC_NMI    = 16'hFFFA;
  localparam logic [15:0] VEC_RST    = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ    = 16'hFFFE;
  localparam logic [7:0]  STACK_PAGE = 8'h01;

  localparam int FLG_I = 2;
  localparam int FLG_B = 4;
  localparam int FLG_U = 5;

  localparam logic [7:0] MASK_I = 8'(1 << FLG_I);
  localparam logic [7:0] MASK_B = 8'(1 << FLG_B);
  localparam logic [7:0] MASK_U = 8'(1 << FLG_U);

endpackage

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
  parameter int N_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_set,
  input  logic [N_SRC-1:0]   src_clr,
  input  logic               nmi_req,
  input  logic               oneshot_req,
  input  logic               ack,
  output logic [N_SRC+1:0]   pend
);

  localparam int OS_BIT  = N_SRC;
  localparam int NMI_BIT = N_SRC + 1;

  logic [N_SRC+1:0] pend_q, pend_d;
  logic             upd_en;

  assign upd_en = (|src_set) | (|src_clr) | nmi_req | oneshot_req | ack;

  always_comb begin
    pend_d                = pend_q;
    pend_d[N_SRC-1:0]     = (pend_q[N_SRC-1:0] & ~src_clr) | src_set;
    pend_d[OS_BIT]        = (pend_q[OS_BIT]  & ~ack) | oneshot_req;
    pend_d[NMI_BIT]       = (pend_q[NMI_BIT] & ~ack) | nmi_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_SRC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pend_q[N_SRC-1:0] & $past(src_set)) == $past(src_set))); // R10

  AST_ACK_DROPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !nmi_req) |=> !pend_q[NMI_BIT]); // R10

  AST_ACK_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(|src_clr)) |=> ((pend_q[N_SRC-1:0] & $past(pend_q[N_SRC-1:0])) == $past(pend_q[N_SRC-1:0]))); // R10

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC+1:0] pend,
  input  logic             irq_masked,
  input  logic             jammed,
  output logic             take_nmi,
  output logic             take_irq
);

  localparam int NMI_BIT = N_SRC + 1;

  logic irq_any;

  assign irq_any  = |pend[N_SRC:0];
  assign take_nmi = pend[NMI_BIT] & ~jammed;
  assign take_irq = irq_any & ~pend[NMI_BIT] & ~irq_masked & ~jammed;

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        take_nmi,
  input  logic        take_irq,
  input  logic [15:0] pc_in,
  input  logic [7:0]  status_in,
  input  logic [7:0]  sp_in,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        ack,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  status_out,
  output logic [7:0]  sp_out,
  output logic        jam_clr
);

  seq_state_e  state_q, state_d;
  entry_kind_e kind_q;
  logic [15:0] pc_sav_q;
  logic [7:0]  p_sav_q;
  logic [7:0]  sp_wk_q;
  logic [7:0]  vec_lo_q;
  logic [15:0] pc_out_q;
  logic [7:0]  st_out_q;
  logic [7:0]  sp_out_q;
  logic        done_q;
  logic        jclr_q;

  logic        start;
  logic        is_push;
  logic        fin;
  logic [15:0] vec_base;
  logic [7:0]  p_clean;
  logic [7:0]  st_new;

  assign start   = (state_q == ST_IDLE) && boundary && (take_nmi || take_irq);
  assign is_push = (state_q == ST_PSH_H) || (state_q == ST_PSH_L) || (state_q == ST_PSH_P);
  assign fin     = (state_q == ST_VEC_H);
  assign p_clean = p_sav_q & ~MASK_B;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_INT1;
      ST_INT1:  state_d = ST_INT2;
      ST_INT2:  state_d = ST_PSH_H;
      ST_PSH_H: state_d = ST_PSH_L;
      ST_PSH_L: state_d = ST_PSH_P;
      ST_PSH_P: state_d = ST_VEC_L;
      ST_VEC_L: state_d = ST_VEC_H;
      ST_VEC_H: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      KIND_NMI: vec_base = VEC_NMI;
      KIND_IRQ: vec_base = VEC_IRQ;
      default:  vec_base = VEC_RST;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      KIND_NMI: st_new = p_clean;
      KIND_IRQ: st_new = p_clean | MASK_I;
      default:  st_new = MASK_I;
    endcase
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PSH_H: begin
        mem_addr  = {STACK_PAGE, sp_wk_q};
        mem_we    = 1'b1;
        mem_wdata = pc_sav_q[15:8];
      end
      ST_PSH_L: begin
        mem_addr  = {STACK_PAGE, sp_wk_q};
        mem_we    = 1'b1;
        mem_wdata = pc_sav_q[7:0];
      end
      ST_PSH_P: begin
        mem_addr  = {STACK_PAGE, sp_wk_q};
        mem_we    = 1'b1;
        mem_wdata = p_clean | MASK_U;
      end
      ST_VEC_L: begin
        mem_addr = vec_base;
        mem_re   = 1'b1;
      end
      ST_VEC_H: begin
        mem_addr = vec_base | 16'h0001;
        mem_re   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_VEC_L;
      kind_q  <= KIND_RST;
    end else begin
      state_q <= state_d;
      if (start) begin
        kind_q <= take_nmi ? KIND_NMI : KIND_IRQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_sav_q <= '0;
      p_sav_q  <= '0;
      sp_wk_q  <= '0;
      vec_lo_q <= '0;
    end else begin
      if (start) begin
        pc_sav_q <= pc_in;
        p_sav_q  <= status_in;
        sp_wk_q  <= sp_in;
      end else if (is_push) begin
        sp_wk_q  <= sp_wk_q - 8'd1;
      end
      if (state_q == ST_VEC_L) begin
        vec_lo_q <= mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out_q <= '0;
      st_out_q <= '0;
      sp_out_q <= '0;
      done_q   <= 1'b0;
      jclr_q   <= 1'b0;
    end else begin
      done_q <= fin;
      jclr_q <= fin && (kind_q == KIND_RST);
      if (fin) begin
        pc_out_q <= {mem_rdata, vec_lo_q};
        st_out_q <= st_new;
        sp_out_q <= (kind_q == KIND_RST) ? sp_in : sp_wk_q;
      end
    end
  end

  assign ack        = start;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign pc_out     = pc_out_q;
  assign status_out = st_out_q;
  assign sp_out     = sp_out_q;
  assign jam_clr    = jclr_q;

  AST_PUSH_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PSH_L || state_q == ST_PSH_P) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1)); // R6

  AST_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state_q == ST_PSH_P) |-> (!mem_wdata[FLG_B] && mem_wdata[FLG_U])); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_IRQ_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && kind_q == KIND_IRQ) |-> status_out[FLG_I]); // R8

  AST_NO_B_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !status_out[FLG_B]); // R8

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && take_nmi) |=> (kind_q == KIND_NMI)); // R4

  AST_BOUNDARY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !boundary) |=> (state_q == ST_IDLE)); // R2

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               jammed,
  input  logic [7:0]         status_prev,
  input  logic [7:0]         status_in,
  input  logic [15:0]        pc_in,
  input  logic [7:0]         sp_in,
  input  logic [N_SRC-1:0]   src_set,
  input  logic [N_SRC-1:0]   src_clr,
  input  logic               nmi_req,
  input  logic               oneshot_req,
  output logic [15:0]        mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [15:0]        pc_out,
  output logic [7:0]         status_out,
  output logic [7:0]         sp_out,
  output logic               jam_clr,
  output logic [N_SRC+1:0]   pend_mask
);

  localparam int NMI_BIT = N_SRC + 1;

  logic [N_SRC+1:0] pend;
  logic             take_nmi;
  logic             take_irq;
  logic             ack;

  irq_pend_mask #(.N_SRC(N_SRC)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_set     (src_set),
    .src_clr     (src_clr),
    .nmi_req     (nmi_req),
    .oneshot_req (oneshot_req),
    .ack         (ack),
    .pend        (pend)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend       (pend),
    .irq_masked (status_prev[FLG_I]),
    .jammed     (jammed),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq)
  );

  irq_entry_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq),
    .pc_in      (pc_in),
    .status_in  (status_in),
    .sp_in      (sp_in),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .ack        (ack),
    .busy       (busy),
    .done       (done),
    .pc_out     (pc_out),
    .status_out (status_out),
    .sp_out     (sp_out),
    .jam_clr    (jam_clr)
  );

  assign pend_mask = pend;

  AST_JAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && jammed) |=> !busy); // R3

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status_prev[FLG_I] && !pend[NMI_BIT]) |=> !busy); // R5

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_nmi && take_irq)); // R4

endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          boundary;
  logic          jammed;
  logic [7:0]    status_prev;
  logic [7:0]    status_in;
  logic [15:0]   pc_in;
  logic [7:0]    sp_in;
  logic [NS-1:0] src_set;
  logic [NS-1:0] src_clr;
  logic          nmi_req;
  logic          oneshot_req;
  logic [15:0]   mem_addr;
  logic          mem_we;
  logic          mem_re;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;
  logic          busy;
  logic          done;
  logic [15:0]   pc_out;
  logic [7:0]    status_out;
  logic [7:0]    sp_out;
  logic          jam_clr;
  logic [NS+1:0] pend_mask;

  always #2.5 clk = ~clk;

  irq_entry_seq #(.N_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .jammed(jammed),
    .status_prev(status_prev), .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
    .src_set(src_set), .src_clr(src_clr), .nmi_req(nmi_req), .oneshot_req(oneshot_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
    .status_out(status_out), .sp_out(sp_out), .jam_clr(jam_clr), .pend_mask(pend_mask)
  );

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = 8'h10;
      16'hFFFB: mem_rdata = 8'hA1;
      16'hFFFC: mem_rdata = 8'h34;
      16'hFFFD: mem_rdata = 8'hC2;
      16'hFFFE: mem_rdata = 8'h56;
      16'hFFFF: mem_rdata = 8'hE3;
      default:  mem_rdata = 8'h00;
    endcase
  end

  // row: {nmi, oneshot, src[3:0], ibit, jam, expect[1:0]}  expect: 0 none, 1 NMI, 2 IRQ
  localparam logic [9:0] ROWS [0:8] = '{
    {1'b0, 1'b0, 4'b0001, 1'b0, 1'b0, 2'd2},
    {1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 2'd1},
    {1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, 2'd1},
    {1'b0, 1'b0, 4'b0100, 1'b1, 1'b0, 2'd0},
    {1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1},
    {1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 2'd2},
    {1'b1, 1'b1, 4'b1111, 1'b0, 1'b1, 2'd0},
    {1'b0, 1'b1, 4'b0000, 1'b1, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 2'd2}
  };

  int n_chk = 0;
  int n_err = 0;
  logic [23:0] wlog [0:3];
  int wcnt;
  int bcnt;
  bit got_done;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse boundary, then follow the sequence, logging writes and busy cycles
  task automatic strobe_and_follow();
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    wcnt = 0;
    got_done = 1'b0;
    bcnt = busy ? 1 : 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1'b1;
        break;
      end
      if (mem_we) begin
        if (wcnt < 4) wlog[wcnt] = {mem_addr, mem_wdata};
        wcnt++;
      end
      if (busy) bcnt++;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    jammed = 1'b0;
    status_prev = 8'h00;
    src_clr = '1;
    @(negedge clk);
    src_clr = '0;
    if (pend_mask[NS+1:NS] != 2'b00) strobe_and_follow();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; boundary = 1'b0; jammed = 1'b0;
    status_prev = 8'h00; status_in = 8'h00; pc_in = 16'h0000; sp_in = 8'hFD;
    src_set = '0; src_clr = '0; nmi_req = 1'b0; oneshot_req = 1'b0;

    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0 && mem_we == 1'b0, "R1 reset outputs",
        {29'd0, busy, done, mem_we}, 32'h4);
    chk(pend_mask == '0, "R1 pending cleared in reset", 32'(pend_mask), 32'h0);
    rst_n = 1'b1;
    wcnt = 0; got_done = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (mem_we) wcnt++;
      @(negedge clk);
      if (done) begin got_done = 1'b1; break; end
    end
    chk(got_done && pc_out == 16'hC234, "R1 reset vector", 32'(pc_out), 32'hC234);
    chk(status_out == 8'h04 && sp_out == 8'hFD, "R1 reset status and sp",
        {16'd0, status_out, sp_out}, {16'd0, 8'h04, 8'hFD});
    chk(jam_clr == 1'b1 && wcnt == 0, "R1 jam release, no writes", {31'd0, jam_clr}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done is one cycle", {30'd0, done, busy}, 32'd0);

    // vector table
    for (int r = 0; r < 9; r++) begin
      logic [9:0]  row;
      logic [15:0] pc_e;
      logic [7:0]  sp_e;
      logic [7:0]  p_e;
      logic [15:0] vec_e;
      logic [7:0]  st_e;
      row  = ROWS[r];
      pc_e = 16'h8000 + 16'(r * 16'h0111);
      sp_e = (r == 2) ? 8'h01 : 8'hF0 - 8'(r);
      p_e  = (r % 2 == 1) ? 8'hC1 : 8'h13;
      @(negedge clk);
      nmi_req = row[9]; oneshot_req = row[8]; src_set = row[7:4];
      pc_in = pc_e; sp_in = sp_e; status_in = p_e;
      @(negedge clk);
      nmi_req = 1'b0; oneshot_req = 1'b0; src_set = '0;
      status_prev = {5'b10000, row[3], 2'b01};
      jammed = row[2];
      strobe_and_follow();
      if (row[1:0] == 2'd0) begin
        // R3 (jammed) / R5 (masked): nothing starts
        chk(!got_done && bcnt == 0, row[2] ? "R3 jammed entry suppressed" : "R5 masked IRQ ignored",
            {31'd0, got_done}, 32'd0);
      end else begin
        vec_e = (row[1:0] == 2'd1) ? 16'hA110 : 16'hE356;
        st_e  = (row[1:0] == 2'd1) ? (p_e & 8'hEF) : ((p_e & 8'hEF) | 8'h04);
        chk(got_done && pc_out == vec_e, (row[1:0] == 2'd1) ? "R4 NMI vector/priority" : "R5 IRQ vector",
            32'(pc_out), 32'(vec_e));
        chk(status_out == st_e, "R8 new status", 32'(status_out), 32'(st_e));
        chk(sp_out == sp_e - 8'd3, "R6 stack pointer after pushes", 32'(sp_out), 32'(8'(sp_e - 8'd3)));
        chk(wcnt == 3 && wlog[0] == {8'h01, sp_e, pc_e[15:8]} && wlog[1] == {8'h01, 8'(sp_e - 8'd1), pc_e[7:0]},
            "R6 push order", {wlog[0][15:0], wlog[1][15:0]}, {sp_e, pc_e[15:8], 8'(sp_e - 8'd1), pc_e[7:0]});
        chk(wlog[2] == {8'h01, 8'(sp_e - 8'd2), ((p_e & 8'hEF) | 8'h20)}, "R7 pushed status",
            32'(wlog[2]), 32'({8'h01, 8'(sp_e - 8'd2), ((p_e & 8'hEF) | 8'h20)}));
        chk(bcnt == 7 && jam_clr == 1'b0, "R9 busy length", 32'(bcnt), 32'd7);
        chk(pend_mask == {2'b00, row[7:4]}, "R10 NMI/one-shot cleared, sources kept",
            32'(pend_mask), 32'({2'b00, row[7:4]}));
      end
      drain();
    end

    // R10: source set and clear
    @(negedge clk); src_set = 4'b0011;
    @(negedge clk); src_set = 4'b0100; src_clr = 4'b0101;
    chk(pend_mask == 6'b000011, "R10 source set", 32'(pend_mask), 32'h03);
    @(negedge clk); src_set = '0; src_clr = '0;
    chk(pend_mask == 6'b000110, "R10 set wins over clear", 32'(pend_mask), 32'h06);
    @(negedge clk); src_clr = '1;
    @(negedge clk); src_clr = '0;
    chk(pend_mask == 6'b000000, "R10 source clear", 32'(pend_mask), 32'h00);

    // R2: boundary during a sequence is ignored; a request stays pending
    status_prev = 8'h00; pc_in = 16'h1234; sp_in = 8'h80; status_in = 8'h00;
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0; boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
    got_done = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) begin got_done = 1'b1; break; end
    end
    chk(got_done && pend_mask[NS+1] == 1'b1, "R2 strobe while busy ignored, NMI kept",
        {30'd0, got_done, pend_mask[NS+1]}, 32'd3);
    bcnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (busy) bcnt++;
    end
    chk(bcnt == 0, "R2 no entry without a boundary strobe", 32'(bcnt), 32'd0);
    drain();

    // R1 / R3: reset acts while jammed
    @(negedge clk); jammed = 1'b1; sp_in = 8'h42; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    got_done = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) begin got_done = 1'b1; break; end
    end
    chk(got_done && pc_out == 16'hC234 && sp_out == 8'h42 && jam_clr,
        "R1 reset while jammed", 32'(pc_out), 32'hC234);
    jammed = 1'b0;

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule